// File: doc/BRIEF.md
# Dual-Slot Vec3 + Scalar Integer Execution Unit

This block executes one instruction per cycle. Each instruction carries two independent operation codes. One code drives a three-lane vector slot, which works on the x, y and z lanes of two four-lane source operands. The other code drives a scalar slot, which works on the w lane of the same two operands. The vector slot runs either a lane-wise add, subtract or multiply, or a three-term dot-product reduction. The reduction lands in a single destination lane that the instruction names.

Operands and results are 16-bit two's-complement integers. Every product and sum wraps to 16 bits. Results and a per-lane write-enable mask appear one clock after an instruction is accepted, so downstream register-file logic can write only the lanes each slot produced. The vector slot writes only x, y or z, and the scalar slot writes only w. The two slots therefore never target the same lane.

Top module: `vliw31_exec`

## Requirements
- R1: While `rst` is low, `in_ready` is 1. An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its result appears with `out_valid`=1 right after that same edge, which is one cycle of latency.
- R2: Lane packing is x in bits [15:0], y in [31:16], z in [47:32] and w in [63:48], for `src_a`, `src_b` and `out_data`. Bit i of `out_wen` enables lane i (0=x, 1=y, 2=z, 3=w).
- R3: Vector codes 0 (add), 1 (subtract a-b) and 2 (multiply) act lane-wise on x, y and z. Each result is truncated to 16 bits, and `out_wen[2:0]`=3'b111.
- R4: Vector code 3 (dot product) computes a.x*b.x + a.y*b.y + a.z*b.z truncated to 16 bits. The result is written to the lane given by `dp_sel` (0=x, 1=y, 2=z, 3 treated as x). Exactly that one bit of `out_wen[2:0]` is set, and the other vector lanes read 0.
- R5: Scalar codes 1 (add), 2 (subtract a.w-b.w) and 3 (multiply) act on w, truncated to 16 bits, with `out_wen[3]`=1. The result is the same whatever the vector code.
- R6: Scalar code 0 is a no-op. `out_wen[3]`=0 and the w lane of `out_data` reads 0.
- R7: Vector results do not depend on the w lanes of the sources, and the scalar result does not depend on the x, y or z lanes.
- R8: While `rst` is high, at the next edge `out_valid`, `out_wen` and `out_data` become 0, and `in_ready` is 0.
- R9: After an edge with no accepted instruction, `out_valid`, `out_wen` and `out_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction |
| vec_op | input | 2 | Vector slot code (0 add, 1 sub, 2 mul, 3 dot) |
| sc_op | input | 2 | Scalar slot code (0 no-op, 1 add, 2 sub, 3 mul) |
| dp_sel | input | 2 | Destination lane of the dot product |
| src_a | input | 64 | First four-lane source |
| src_b | input | 64 | Second four-lane source |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Four-lane result |
| out_wen | output | 4 | Per-lane write enable |

## Verification
On every cycle, the assertions check the one-cycle valid timing and the write-enable pattern that each vector and scalar code must produce. This covers the single dot-product lane chosen by the selector and the w write being suppressed on a no-op. They also check the scalar add value and the all-zero idle output. The arithmetic itself can only be shown by the bench's scenarios, which compare each result with a model. These scenarios cover wrap-around on products and reductions, every dot-product destination including the aliased code, and insensitivity to the lanes a slot must ignore.

// File: rtl/vliw31_pkg.sv
package vliw31_pkg;
  localparam int LANES    = 4;
  localparam int VEC_LNS  = 3;
  localparam int OP_W     = 2;

  typedef enum logic [OP_W-1:0] {
    VOP_ADD = 2'd0,
    VOP_SUB = 2'd1,
    VOP_MUL = 2'd2,
    VOP_DOT = 2'd3
  } vop_e;

  typedef enum logic [OP_W-1:0] {
    SOP_NOP = 2'd0,
    SOP_ADD = 2'd1,
    SOP_SUB = 2'd2,
    SOP_MUL = 2'd3
  } sop_e;
endpackage

// File: rtl/vliw31_vec_slot.sv
module vliw31_vec_slot
  import vliw31_pkg::*;
#(
  parameter int LW = 16
) (
  input  vop_e                   op,
  input  logic [1:0]             dst_sel,
  input  logic [VEC_LNS*LW-1:0]  a_v,
  input  logic [VEC_LNS*LW-1:0]  b_v,
  output logic [VEC_LNS*LW-1:0]  res_v,
  output logic [VEC_LNS-1:0]     wen_v
);
  logic [LW-1:0] prod [VEC_LNS];
  logic [LW-1:0] elem [VEC_LNS];
  logic [LW-1:0] dot_sum;
  logic [1:0]    tgt;

  genvar gi;
  generate
    for (gi = 0; gi < VEC_LNS; gi++) begin : g_lane
      logic [LW-1:0] av, bv;
      assign av = a_v[gi*LW +: LW];
      assign bv = b_v[gi*LW +: LW];
      assign prod[gi] = av * bv;
      always_comb begin
        case (op)
          VOP_ADD: elem[gi] = av + bv;
          VOP_SUB: elem[gi] = av - bv;
          default: elem[gi] = prod[gi];
        endcase
      end
      always_comb begin
        if (op == VOP_DOT) begin
          res_v[gi*LW +: LW] = (tgt == 2'(gi)) ? dot_sum : '0;
          wen_v[gi]          = (tgt == 2'(gi));
        end else begin
          res_v[gi*LW +: LW] = elem[gi];
          wen_v[gi]          = 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    dot_sum = '0;
    for (int i = 0; i < VEC_LNS; i++) dot_sum = dot_sum + prod[i];
  end

  assign tgt = (dst_sel == 2'd3) ? 2'd0 : dst_sel;
endmodule

// File: rtl/vliw31_scalar_slot.sv
module vliw31_scalar_slot
  import vliw31_pkg::*;
#(
  parameter int LW = 16
) (
  input  sop_e          op,
  input  logic [LW-1:0] a_s,
  input  logic [LW-1:0] b_s,
  output logic [LW-1:0] res_s,
  output logic          wen_s
);
  always_comb begin
    wen_s = 1'b1;
    case (op)
      SOP_ADD: res_s = a_s + b_s;
      SOP_SUB: res_s = a_s - b_s;
      SOP_MUL: res_s = a_s * b_s;
      default: begin
        res_s = '0;
        wen_s = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/vliw31_result_reg.sv
module vliw31_result_reg #(
  parameter int DW = 64,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] d_data,
  input  logic [EW-1:0] d_wen,
  output logic          q_valid,
  output logic [DW-1:0] q_data,
  output logic [EW-1:0] q_wen
);
  always_ff @(posedge clk) begin
    if (rst || !load) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_wen   <= '0;
    end else begin
      q_valid <= 1'b1;
      q_data  <= d_data;
      q_wen   <= d_wen;
    end
  end
endmodule

// File: rtl/vliw31_exec.sv
module vliw31_exec
  import vliw31_pkg::*;
#(
  parameter int LW = 16,
  localparam int DW = LANES * LW,
  localparam int VW = VEC_LNS * LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    vec_op,
  input  logic [1:0]    sc_op,
  input  logic [1:0]    dp_sel,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [3:0]    out_wen
);
  logic          rdy_q;
  logic          fire;
  logic [VW-1:0] v_res;
  logic [2:0]    v_wen;
  logic [LW-1:0] s_res;
  logic          s_wen;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign fire     = in_valid && rdy_q;

  vliw31_vec_slot #(.LW(LW)) u_vec (
    .op      (vop_e'(vec_op)),
    .dst_sel (dp_sel),
    .a_v     (src_a[VW-1:0]),
    .b_v     (src_b[VW-1:0]),
    .res_v   (v_res),
    .wen_v   (v_wen)
  );

  vliw31_scalar_slot #(.LW(LW)) u_sc (
    .op    (sop_e'(sc_op)),
    .a_s   (src_a[DW-1 -: LW]),
    .b_s   (src_b[DW-1 -: LW]),
    .res_s (s_res),
    .wen_s (s_wen)
  );

  vliw31_result_reg #(.DW(DW), .EW(LANES)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (fire),
    .d_data  ({s_res, v_res}),
    .d_wen   ({s_wen, v_wen}),
    .q_valid (out_valid),
    .q_data  (out_data),
    .q_wen   (out_wen)
  );
endmodule

// File: rtl/vliw31_exec_chk.sv
module vliw31_exec_chk #(
  parameter int LW = 16,
  localparam int DW = 4 * LW
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    vec_op,
  input logic [1:0]    sc_op,
  input logic [1:0]    dp_sel,
  input logic [DW-1:0] src_a,
  input logic [DW-1:0] src_b,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic [3:0]    out_wen
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);
  a_r9_no_accept: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !out_valid);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_wen == 4'd0 && out_data == '0));
  a_r3_lanewise_wen: assert property (@(posedge clk) disable iff (rst)
    (acc && vec_op != 2'd3) |=> out_wen[2:0] == 3'b111);
  a_r4_dot_lane: assert property (@(posedge clk) disable iff (rst)
    (acc && vec_op == 2'd3) |=>
      out_wen[2:0] == (($past(dp_sel) == 2'd3) ? 3'b001 : (3'b001 << $past(dp_sel))));
  a_r5_scalar_wen: assert property (@(posedge clk) disable iff (rst)
    (acc && sc_op != 2'd0) |=> out_wen[3]);
  a_r5_scalar_add: assert property (@(posedge clk) disable iff (rst)
    (acc && sc_op == 2'd1) |=>
      out_data[DW-1 -: LW] == LW'($past(src_a[DW-1 -: LW]) + $past(src_b[DW-1 -: LW])));
  a_r6_nop: assert property (@(posedge clk) disable iff (rst)
    (acc && sc_op == 2'd0) |=> (!out_wen[3] && out_data[DW-1 -: LW] == '0));
endmodule

bind vliw31_exec vliw31_exec_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .vec_op(vec_op), .sc_op(sc_op), .dp_sel(dp_sel),
  .src_a(src_a), .src_b(src_b),
  .out_valid(out_valid), .out_data(out_data), .out_wen(out_wen)
);

// File: tb/vliw31_exec_bench.sv
module vliw31_exec_bench;
  localparam int CLK_P = 10;
  localparam int LW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  vec_op = '0, sc_op = '0, dp_sel = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [3:0]  out_wen;

  int total = 0;
  int bad = 0;
  logic [63:0] last_data;

  always #(CLK_P/2) clk = ~clk;

  vliw31_exec #(.LW(LW)) u_vliw31_exec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .vec_op(vec_op), .sc_op(sc_op), .dp_sel(dp_sel),
    .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_data(out_data), .out_wen(out_wen)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pk(logic [15:0] x, logic [15:0] y,
                                     logic [15:0] z, logic [15:0] w);
    return {w, z, y, x};
  endfunction

  // expected {wen, data}
  function automatic logic [67:0] model(logic [1:0] v, logic [1:0] s, logic [1:0] sel,
                                        logic [63:0] a, logic [63:0] b);
    logic [15:0] r [4];
    logic [3:0]  we;
    logic [15:0] d;
    int t;
    we = 4'b0000;
    for (int i = 0; i < 4; i++) r[i] = 16'h0;
    if (v == 2'd3) begin
      d = 16'(a[15:0] * b[15:0]) + 16'(a[31:16] * b[31:16]) + 16'(a[47:32] * b[47:32]);
      t = (sel == 2'd3) ? 0 : int'(sel);
      r[t] = d;
      we[t] = 1'b1;
    end else begin
      for (int i = 0; i < 3; i++) begin
        case (v)
          2'd0: r[i] = a[i*16 +: 16] + b[i*16 +: 16];
          2'd1: r[i] = a[i*16 +: 16] - b[i*16 +: 16];
          default: r[i] = 16'(a[i*16 +: 16] * b[i*16 +: 16]);
        endcase
      end
      we[2:0] = 3'b111;
    end
    case (s)
      2'd1: begin r[3] = a[63:48] + b[63:48]; we[3] = 1'b1; end
      2'd2: begin r[3] = a[63:48] - b[63:48]; we[3] = 1'b1; end
      2'd3: begin r[3] = 16'(a[63:48] * b[63:48]); we[3] = 1'b1; end
      default: ;
    endcase
    return {we, r[3], r[2], r[1], r[0]};
  endfunction

  // called at a falling edge; returns at the falling edge after the result
  task automatic issue(string req, logic [1:0] v, logic [1:0] s, logic [1:0] sel,
                       logic [63:0] a, logic [63:0] b);
    logic [67:0] e;
    vec_op = v; sc_op = s; dp_sel = sel; src_a = a; src_b = b; in_valid = 1'b1;
    e = model(v, s, sel, a, b);
    @(posedge clk);
    @(negedge clk);
    check({req, " R1 valid"}, 64'(out_valid), 64'd1);
    check({req, " wen"}, 64'(out_wen), 64'(e[67:64]));
    check({req, " data"}, out_data, e[63:0]);
    last_data = out_data;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] keep;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 out_valid", 64'(out_valid), 64'd0);
    check("R8 out_wen", 64'(out_wen), 64'd0);
    check("R8 out_data", out_data, 64'd0);
    check("R8 in_ready", 64'(in_ready), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 in_ready", 64'(in_ready), 64'd1);

    // R3 / R5 / R2: lane-wise add with scalar subtract
    issue("R3 R5 add/sub", 2'd0, 2'd2, 2'd0,
          pk(16'd1, 16'd2, 16'd3, 16'd10), pk(16'd100, 16'd200, 16'd300, 16'd4));
    check("R2 x lane", 64'(out_data[15:0]), 64'd101);
    // R3 subtract wrap, scalar multiply
    issue("R3 R5 sub/mul", 2'd1, 2'd3, 2'd0,
          pk(16'd0, 16'd5, 16'h8000, 16'd300), pk(16'd1, 16'd7, 16'd1, 16'd300));
    // R3 multiply truncation
    issue("R3 mul trunc", 2'd2, 2'd1, 2'd0,
          pk(16'h7fff, 16'h0100, 16'hffff, 16'hffff), pk(16'd2, 16'h0100, 16'hffff, 16'd1));
    // R4 dot product to every destination, including aliased code 3
    for (int k = 0; k < 4; k++)
      issue("R4 dot", 2'd3, 2'd3, 2'(k),
            pk(16'd3, 16'd4, 16'd5, 16'd6), pk(16'd7, 16'd8, 16'd9, 16'd2));
    // R4 dot wrap
    issue("R4 dot wrap", 2'd3, 2'd0, 2'd2,
          pk(16'h4000, 16'h4000, 16'h4000, 16'd0), pk(16'd4, 16'd4, 16'd4, 16'd0));
    // R6: scalar no-op
    issue("R6 nop", 2'd0, 2'd0, 2'd0,
          pk(16'd9, 16'd9, 16'd9, 16'hbeef), pk(16'd1, 16'd1, 16'd1, 16'h1234));
    check("R6 w lane zero", 64'(out_data[63:48]), 64'd0);
    // R9: idle cycle after result
    @(negedge clk);
    check("R9 idle valid", 64'(out_valid), 64'd0);
    check("R9 idle wen", 64'(out_wen), 64'd0);
    check("R9 idle data", out_data, 64'd0);
    // R7: w lanes do not affect vector slot, xyz lanes do not affect scalar slot
    issue("R7 base", 2'd2, 2'd1, 2'd0,
          pk(16'd11, 16'd12, 16'd13, 16'd1), pk(16'd21, 16'd22, 16'd23, 16'd2));
    keep = last_data;
    issue("R7 w changed", 2'd2, 2'd1, 2'd0,
          pk(16'd11, 16'd12, 16'd13, 16'h7777), pk(16'd21, 16'd22, 16'd23, 16'h1111));
    check("R7 xyz unchanged", 64'(last_data[47:0]), 64'(keep[47:0]));
    issue("R7 xyz changed", 2'd3, 2'd1, 2'd1,
          pk(16'hffff, 16'h1234, 16'h0f0f, 16'd1), pk(16'h5555, 16'h00aa, 16'h0003, 16'd2));
    check("R7 w unchanged", 64'(last_data[63:48]), 64'(keep[63:48]));

    // random mix with back-to-back issue (R1 R3 R4 R5 R6)
    for (int n = 0; n < 300; n++) begin
      issue("R1 random", 2'($urandom), 2'($urandom), 2'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom});
    end

    // R8: reset mid-stream clears outputs
    vec_op = 2'd0; sc_op = 2'd1; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R8 mid valid", 64'(out_valid), 64'd0);
    check("R8 mid ready", 64'(in_ready), 64'd0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule